// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block collects interrupt conditions for a small processor core and turns them into one request line toward the core plus a separate wake-up line for a sleeping core. Seven conditions feed it: an edge on an external pin, overflow of a first timer, a change on any of six I/O pins, a comparator change, an end of conversion from an analog converter, overflow of a second timer, and completion of a data memory write. Each condition latches a flag bit that is set whatever the enables say. The three core conditions (external edge, first timer, pin change) are enabled in the control register. The four peripheral conditions have their own flag register and enable register, and their combined result is gated by a peripheral-group enable. A global enable gates the final request to the core. The wake-up line ignores the global enable.

Pin change detection passes the six pins through a two-stage synchroniser. It compares them against a snapshot that is refreshed whenever software reads the port register. The external pin is synchronised the same way, and a select bit picks whether its rising or falling edge counts. A small sequencer tracks the request. It has three states:
- IDLE: nothing asserted.
- REQ: request asserted.
- SVC: handler running.

Its transitions are:
- IDLE to REQ, when an enabled source is pending and the global enable is set.
- REQ back to IDLE, when that condition goes away.
- REQ to SVC, on the vector-taken acknowledge. This clears the global enable.
- SVC to IDLE, on the return-from-interrupt input. This sets the global enable again.

The vector address output always carries 0x0004.

Top module: `irq_two_level`

## Requirements
- R1: A source event pulse sets its flag on the next clock edge whatever the state of its own enable, the group enable or the global enable. In the control register (select 0) the flags are bit 5 (external edge), bit 6 (first timer) and bit 7 (pin change). In the peripheral flag register (select 1) they are bit 0 (comparator), bit 1 (converter), bit 2 (second timer) and bit 3 (memory write).
- R2: When an enabled source is pending and the global enable (control bit 0) is set at a clock edge, `irq_req` is high from that edge on. A core source counts as enabled through control bit 2 (external edge), bit 3 (first timer) or bit 4 (pin change).
- R3: A peripheral flag contributes only when its enable bit (select 2, same bit position) and the group enable (control bit 1) are both set.
- R4: `wake_req` is high combinationally whenever an enabled source is pending, even with the global enable clear; `irq_req` stays low while the global enable is clear.
- R5: With the pin change enable bit set (select 3, bits 5:0), a synchronised pin value that differs from the value latched at the last port read (select 4 with `reg_rd`) sets the pin change flag. Disabled pins never set it. After a port read, the latched value matches the pins, so no further mismatch arises.
- R6: Select 3 bit 7 picks the external edge: 1 means rising, 0 means falling. Only the chosen edge sets the external flag.
- R7: `vec_taken` while `irq_req` is high clears the global enable and drops `irq_req` on the next edge. `vec_addr` is always 0x0004.
- R8: `ret_irq` in the SVC state sets the global enable at the next edge, and the request can then reassert.
- R9: A source event in the same cycle as a software write that clears its flag leaves the flag set.
- R10: After reset, all registers read zero, and `irq_req` and `wake_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (latches port snapshot on select 4) |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| pin_in | input | 6 | Asynchronous I/O pins for change detection |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| ev_tmr | input | 1 | First timer overflow pulse |
| ev_cmp | input | 1 | Comparator change pulse |
| ev_adc | input | 1 | Conversion done pulse |
| ev_tmr2 | input | 1 | Second timer overflow pulse |
| ev_mem | input | 1 | Memory write done pulse |
| vec_taken | input | 1 | Core acknowledges the vector |
| ret_irq | input | 1 | Return from interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| wake_req | output | 1 | Wake-up request |
| vec_addr | output | 13 | Interrupt vector address |

## Verification
A random stream of peripheral event pulses is mixed with register writes that toggle individual enables and flags. It is compared cycle by cycle against a model of the gating. This separates the global gate, which affects only the request, from the group gate, which affects both outputs, and from the per-source enables. Directed sequences then cover the remaining cases:
- Disabled versus enabled pins, before and after a port read, show that the snapshot and the enable mask work.
- Both external pin directions under each edge select show that the select picks the right edge.
- Acknowledge and return pulses step the sequencer through SVC.
- A write that clears a flag in the same cycle as its event separates set-wins from write-wins.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int REG_W      = 8;
    localparam int SEL_W      = 3;
    localparam int NUM_PERIPH = 4;

    localparam logic [SEL_W-1:0] SEL_CTL  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_PFLG = 3'd1;
    localparam logic [SEL_W-1:0] SEL_PEN  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_PCEN = 3'd3;
    localparam logic [SEL_W-1:0] SEL_PORT = 3'd4;

    // control register bit positions
    localparam int B_GIE    = 0;
    localparam int B_PIE    = 1;
    localparam int B_EXT_EN = 2;
    localparam int B_TMR_EN = 3;
    localparam int B_PC_EN  = 4;
    localparam int B_EXT_F  = 5;
    localparam int B_TMR_F  = 6;
    localparam int B_PC_F   = 7;

    // pin-change enable register: edge select position
    localparam int B_EDGE   = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_SVC  = 2'd2
    } irq_state_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= d;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/irq_ext_edge.sv
module irq_ext_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic sel_rise,
    output logic edge_evt
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
        end
    end

    always_comb begin
        if (sel_rise) begin
            edge_evt = pin_s & ~prev_q;
        end else begin
            edge_evt = ~pin_s & prev_q;
        end
    end

endmodule

// File: rtl/irq_pin_change.sv
module irq_pin_change #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_s,
    input  logic [N-1:0] pin_en,
    input  logic         rd_strobe,
    output logic         change
);

    logic [N-1:0] snap_q;
    logic [N-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (rd_strobe) begin
            snap_q <= pin_s;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign diff[i] = (pin_s[i] ^ snap_q[i]) & pin_en[i];
    end

    assign change = |diff;

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_gated,
    input  logic vec_taken,
    input  logic ret_irq,
    output logic irq_req,
    output logic in_svc,
    output logic gie_clr,
    output logic gie_set
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pend_gated) state_d = ST_REQ;
            ST_REQ: begin
                if (vec_taken)        state_d = ST_SVC;
                else if (!pend_gated) state_d = ST_IDLE;
            end
            ST_SVC:  if (ret_irq) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_req = (state_q == ST_REQ);
        in_svc  = (state_q == ST_SVC);
        gie_clr = (state_q == ST_REQ) && vec_taken;
        gie_set = (state_q == ST_SVC) && ret_irq;
    end

endmodule

// File: rtl/irq_two_level.sv
module irq_two_level
    import irq_pkg::*;
#(
    parameter int NUM_PINS    = 6,
    parameter int SYNC_STAGES = 2,
    parameter int VEC_W       = 13,
    parameter int VEC_ADDR    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                ext_pin,
    input  logic                ev_tmr,
    input  logic                ev_cmp,
    input  logic                ev_adc,
    input  logic                ev_tmr2,
    input  logic                ev_mem,
    input  logic                vec_taken,
    input  logic                ret_irq,
    output logic                irq_req,
    output logic                wake_req,
    output logic [VEC_W-1:0]    vec_addr
);

    localparam logic [VEC_W-1:0] VEC_CONST = VEC_W'(VEC_ADDR);

    logic gie_q, pie_q, ext_en_q, tmr_en_q, pc_en_q;
    logic ext_flag_q, tmr_flag_q, pc_flag_q;
    logic [NUM_PERIPH-1:0] pflag_q, pen_q, periph_ev;
    logic [NUM_PINS-1:0]   pcen_q, pin_s;
    logic edge_rise_q;
    logic ext_s, ext_evt, pc_evt;
    logic wr_ctl, wr_pflg, wr_pen, wr_pcen, rd_port;
    logic pend_core, pend_per, pend_any;
    logic in_svc, gie_clr, gie_set;
    logic unused_wdata_bits;

    assign wr_ctl  = reg_wr && (reg_sel == SEL_CTL);
    assign wr_pflg = reg_wr && (reg_sel == SEL_PFLG);
    assign wr_pen  = reg_wr && (reg_sel == SEL_PEN);
    assign wr_pcen = reg_wr && (reg_sel == SEL_PCEN);
    assign rd_port = reg_rd && (reg_sel == SEL_PORT);
    assign unused_wdata_bits = ^reg_wdata[B_EDGE-1:NUM_PINS];

    irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
    );

    irq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_s)
    );

    irq_ext_edge u_ext_edge (
        .clk(clk), .rst_n(rst_n), .pin_s(ext_s),
        .sel_rise(edge_rise_q), .edge_evt(ext_evt)
    );

    irq_pin_change #(.N(NUM_PINS)) u_pin_change (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .pin_en(pcen_q),
        .rd_strobe(rd_port), .change(pc_evt)
    );

    // control register: enables and core flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_q      <= 1'b0;
            pie_q      <= 1'b0;
            ext_en_q   <= 1'b0;
            tmr_en_q   <= 1'b0;
            pc_en_q    <= 1'b0;
            ext_flag_q <= 1'b0;
            tmr_flag_q <= 1'b0;
            pc_flag_q  <= 1'b0;
        end else begin
            if (wr_ctl) begin
                pie_q    <= reg_wdata[B_PIE];
                ext_en_q <= reg_wdata[B_EXT_EN];
                tmr_en_q <= reg_wdata[B_TMR_EN];
                pc_en_q  <= reg_wdata[B_PC_EN];
            end
            ext_flag_q <= (wr_ctl ? reg_wdata[B_EXT_F] : ext_flag_q) | ext_evt;
            tmr_flag_q <= (wr_ctl ? reg_wdata[B_TMR_F] : tmr_flag_q) | ev_tmr;
            pc_flag_q  <= (wr_ctl ? reg_wdata[B_PC_F]  : pc_flag_q)  | pc_evt;
            if (gie_clr) begin
                gie_q <= 1'b0;
            end else if (gie_set) begin
                gie_q <= 1'b1;
            end else if (wr_ctl) begin
                gie_q <= reg_wdata[B_GIE];
            end
        end
    end

    assign periph_ev = {ev_mem, ev_tmr2, ev_adc, ev_cmp};

    // peripheral flags, peripheral enables, pin-change enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pflag_q     <= '0;
            pen_q       <= '0;
            pcen_q      <= '0;
            edge_rise_q <= 1'b0;
        end else begin
            pflag_q <= (wr_pflg ? reg_wdata[NUM_PERIPH-1:0] : pflag_q) | periph_ev;
            if (wr_pen) begin
                pen_q <= reg_wdata[NUM_PERIPH-1:0];
            end
            if (wr_pcen) begin
                pcen_q      <= reg_wdata[NUM_PINS-1:0];
                edge_rise_q <= reg_wdata[B_EDGE];
            end
        end
    end

    assign pend_core = (ext_flag_q & ext_en_q) | (tmr_flag_q & tmr_en_q) | (pc_flag_q & pc_en_q);
    assign pend_per  = pie_q & (|(pflag_q & pen_q));
    assign pend_any  = pend_core | pend_per;
    assign wake_req  = pend_any;
    assign vec_addr  = VEC_CONST;

    irq_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pend_gated(pend_any & gie_q),
        .vec_taken(vec_taken), .ret_irq(ret_irq), .irq_req(irq_req),
        .in_svc(in_svc), .gie_clr(gie_clr), .gie_set(gie_set)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTL: begin
                reg_rdata[B_GIE]    = gie_q;
                reg_rdata[B_PIE]    = pie_q;
                reg_rdata[B_EXT_EN] = ext_en_q;
                reg_rdata[B_TMR_EN] = tmr_en_q;
                reg_rdata[B_PC_EN]  = pc_en_q;
                reg_rdata[B_EXT_F]  = ext_flag_q;
                reg_rdata[B_TMR_F]  = tmr_flag_q;
                reg_rdata[B_PC_F]   = pc_flag_q;
            end
            SEL_PFLG: reg_rdata[NUM_PERIPH-1:0] = pflag_q;
            SEL_PEN:  reg_rdata[NUM_PERIPH-1:0] = pen_q;
            SEL_PCEN: begin
                reg_rdata[NUM_PINS-1:0] = pcen_q;
                reg_rdata[B_EDGE]       = edge_rise_q;
            end
            SEL_PORT: reg_rdata[NUM_PINS-1:0] = pin_s;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_two_level_chk.sv
module irq_two_level_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_req,
    input logic wake_req,
    input logic vec_taken,
    input logic ret_irq,
    input logic ev_tmr,
    input logic ev_cmp,
    input logic gie,
    input logic in_svc,
    input logic tmr_flag,
    input logic pflag0
);

    // R1
    flag_sets_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tmr |=> tmr_flag);

    // R2
    req_needs_gated_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(gie && wake_req));

    // R4
    req_implies_wake_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !$past(gie)) |-> 1'b0);

    // R7
    ack_clears_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && vec_taken) |=> (!gie && !irq_req));

    // R8
    return_sets_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_svc && ret_irq) |=> gie);

    // R9
    event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cmp |=> pflag0);

endmodule

bind irq_two_level irq_two_level_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .wake_req(wake_req),
    .vec_taken(vec_taken), .ret_irq(ret_irq), .ev_tmr(ev_tmr), .ev_cmp(ev_cmp),
    .gie(gie_q), .in_svc(in_svc), .tmr_flag(tmr_flag_q), .pflag0(pflag_q[0])
);

// File: tb/irq_two_level_tb.sv
module irq_two_level_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [5:0] pin_in = '0;
    logic       ext_pin = 1'b0;
    logic       ev_tmr = 0, ev_cmp = 0, ev_adc = 0, ev_tmr2 = 0, ev_mem = 0;
    logic       vec_taken = 0, ret_irq = 0;
    logic       irq_req, wake_req;
    logic [12:0] vec_addr;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_two_level u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .ext_pin(ext_pin), .ev_tmr(ev_tmr), .ev_cmp(ev_cmp),
        .ev_adc(ev_adc), .ev_tmr2(ev_tmr2), .ev_mem(ev_mem),
        .vec_taken(vec_taken), .ret_irq(ret_irq), .irq_req(irq_req),
        .wake_req(wake_req), .vec_addr(vec_addr)
    );

    function automatic logic f_pend(input logic [7:0] c, input logic [3:0] pf, input logic [3:0] pe);
        return (c[5] & c[2]) | (c[6] & c[3]) | (c[7] & c[4]) | (c[1] & (|(pf & pe)));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] sel, input logic [7:0] mask, input logic [7:0] exp);
        reg_sel = sel;
        #1;
        chk(req, reg_rdata & mask, exp);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] m_ctl;
        logic [3:0] m_pf, m_pe;
        logic       m_irq;
        void'($urandom(32'h5EED_0C1A));

        // random phase
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ctl = '0; m_pf = '0; m_pe = '0; m_irq = 1'b0;
        for (int c = 0; c < N_RAND; c++) begin
            logic [7:0] n_ctl;
            logic [3:0] n_pf, n_pe;
            reg_wr    = ($urandom % 4) == 0;
            reg_sel   = 3'($urandom % 3);
            reg_wdata = 8'($urandom);
            ev_tmr  = ($urandom % 8) == 0;
            ev_cmp  = ($urandom % 8) == 0;
            ev_adc  = ($urandom % 8) == 0;
            ev_tmr2 = ($urandom % 8) == 0;
            ev_mem  = ($urandom % 8) == 0;
            #1;
            chk("R2 random irq_req", irq_req, m_irq);
            chk("R3/R4 random wake_req", wake_req, f_pend(m_ctl, m_pf, m_pe));
            chk("R1 random readback", reg_rdata,
                reg_sel == 3'd0 ? m_ctl : (reg_sel == 3'd1 ? {4'h0, m_pf} : {4'h0, m_pe}));
            n_ctl = (reg_wr && reg_sel == 3'd0) ? reg_wdata : m_ctl;
            n_ctl[6] = n_ctl[6] | ev_tmr;
            n_pf = ((reg_wr && reg_sel == 3'd1) ? reg_wdata[3:0] : m_pf) | {ev_mem, ev_tmr2, ev_adc, ev_cmp};
            n_pe = (reg_wr && reg_sel == 3'd2) ? reg_wdata[3:0] : m_pe;
            m_irq = m_ctl[0] & f_pend(m_ctl, m_pf, m_pe);
            @(posedge clk);
            m_ctl = n_ctl; m_pf = n_pf; m_pe = n_pe;
            @(negedge clk);
        end
        reg_wr = 0; ev_tmr = 0; ev_cmp = 0; ev_adc = 0; ev_tmr2 = 0; ev_mem = 0;

        // R10 reset state
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
        rd_chk("R10 ctl", 3'd0, 8'hFF, 8'h00);
        rd_chk("R10 pflag", 3'd1, 8'hFF, 8'h00);
        rd_chk("R10 pen", 3'd2, 8'hFF, 8'h00);
        rd_chk("R10 pcen", 3'd3, 8'hFF, 8'h00);
        chk("R10 irq_req", irq_req, 0);
        chk("R10 wake_req", wake_req, 0);
        chk("R7 vec_addr", vec_addr, 13'h0004);

        // R1 flag set with everything disabled
        ev_adc = 1; step(1); ev_adc = 0;
        rd_chk("R1 converter flag", 3'd1, 8'hFF, 8'h02);
        chk("R1 no wake", wake_req, 0);
        // R3 own enable alone is not enough
        wr(3'd2, 8'h02);
        chk("R3 group gate blocks", wake_req, 0);
        // R4 group enable, global clear
        wr(3'd0, 8'h02);
        chk("R4 wake without global", wake_req, 1);
        step(1);
        chk("R4 no irq without global", irq_req, 0);
        // R2 global set
        wr(3'd0, 8'h03);
        chk("R2 irq not before next edge", irq_req, 0);
        step(1);
        chk("R2 irq asserted", irq_req, 1);
        // R7 acknowledge
        vec_taken = 1; step(1); vec_taken = 0;
        chk("R7 irq dropped", irq_req, 0);
        rd_chk("R7 global cleared", 3'd0, 8'hFF, 8'h02);
        step(2);
        chk("R7 stays low in service", irq_req, 0);
        // R8 return
        ret_irq = 1; step(1); ret_irq = 0;
        rd_chk("R8 global set", 3'd0, 8'hFF, 8'h03);
        step(1);
        chk("R8 irq reasserts", irq_req, 1);
        wr(3'd1, 8'h00);
        chk("R3 wake drops after clear", wake_req, 0);
        wr(3'd0, 8'h00);
        chk("R2 irq drops", irq_req, 0);

        // R9 event beats clear
        ev_cmp = 1; step(1);
        reg_wr = 1; reg_sel = 3'd1; reg_wdata = 8'h00;
        step(1);
        reg_wr = 0; ev_cmp = 0;
        rd_chk("R9 peripheral flag kept", 3'd1, 8'hFF, 8'h01);
        ev_tmr = 1; reg_wr = 1; reg_sel = 3'd0; reg_wdata = 8'h00;
        step(1);
        reg_wr = 0; ev_tmr = 0;
        rd_chk("R9 timer flag kept", 3'd0, 8'hFF, 8'h40);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);

        // R5 pin change
        wr(3'd3, 8'h05);
        pin_in = 6'b000010;
        step(4);
        rd_chk("R5 disabled pin ignored", 3'd0, 8'h80, 8'h00);
        pin_in = 6'b000110;
        step(3);
        rd_chk("R5 enabled pin flags", 3'd0, 8'h80, 8'h80);
        reg_rd = 1; reg_sel = 3'd4;
        #1;
        chk("R5 port value", reg_rdata, 8'h06);
        step(1);
        reg_rd = 0;
        wr(3'd0, 8'h00);
        step(2);
        rd_chk("R5 no change after read", 3'd0, 8'h80, 8'h00);

        // R6 edge select
        wr(3'd3, 8'h80);
        ext_pin = 1; step(4);
        rd_chk("R6 rising edge flags", 3'd0, 8'h20, 8'h20);
        wr(3'd0, 8'h00);
        ext_pin = 0; step(4);
        rd_chk("R6 falling ignored when rising", 3'd0, 8'h20, 8'h00);
        wr(3'd3, 8'h00);
        ext_pin = 1; step(4);
        rd_chk("R6 rising ignored when falling", 3'd0, 8'h20, 8'h00);
        ext_pin = 0; step(4);
        rd_chk("R6 falling edge flags", 3'd0, 8'h20, 8'h20);
        // R2 core source through enable and global
        wr(3'd0, 8'h25);
        step(1);
        chk("R2 core source irq", irq_req, 1);

        summary();
        $finish;
    end

endmodule